// File: doc/BRIEF.md
# Rate-Emulating Bit Repeater

This block sits on a byte-wide transmit path that runs at the STS-12 byte rate and lets the same full-rate serial link feed a far-end receiver that runs at one quarter of that rate (STS-3, 155 Mbit/s on a 622 Mbit/s line). In the full-rate mode each input byte leaves unchanged. In the quarter-rate mode the input is known to carry four identical STS-3 copies, so only the first byte of each group of four is kept. That byte is spread over four output bytes in which every bit appears four times in a row. A receiver sampling at a quarter of the line rate then sees one clean bit per sample.

A frame-sync strobe marks the first byte of a group. It also latches the mode select, so a mode change never splits an expansion group. Both modes have the same one-cycle latency from the input port to the registered output. Cycles with the valid strobe low neither advance the group position nor change the output byte.

Top module: `bitrep_top`

## Requirements
- R1: While reset is high, and on the first cycle after it, out_valid is 0 and out_data is 0x00.
- R2: In full-rate mode (latched mode 0), every valid input byte appears on out_data exactly one clock later, unchanged.
- R3: In quarter-rate mode (latched mode 1), the kept byte b produces four output bytes in order k=0..3. Output byte k is {4{b[7-2k]}, 4{b[6-2k]}}: MSB first, each bit repeated four times. For example, 0xA5 gives F0, F0, 0F, 0F.
- R4: In quarter-rate mode, the contents of the second, third and fourth input bytes of a group have no effect on out_data.
- R5: A valid byte with in_sync high is always byte 0 of a new group, whatever the group position was before.
- R6: mode_sel is sampled only on a valid byte with in_sync high. Changing it at any other time has no effect until the next such byte.
- R7: out_valid equals in_valid delayed by one clock, in both modes.
- R8: A cycle with in_valid low leaves the group position and out_data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 8 | Input byte |
| in_valid | input | 1 | Input byte is valid |
| in_sync | input | 1 | Marks the first byte of a group and latches the mode |
| mode_sel | input | 1 | 0 = full-rate pass-through, 1 = quarter-rate expansion |
| out_data | output | 8 | Registered output byte |
| out_valid | output | 1 | Registered output valid |

## Verification
A wrong group-position counter shows at the ports on the very next output byte: the expansion either takes the wrong bit pair or reloads the held byte from a byte that should have been discarded. A wrong latched mode turns expanded nibble patterns into raw bytes, or the reverse, within one cycle. The bench therefore checks every output byte of each group, across idle gaps, forced resyncs and deferred mode changes, rather than only the first byte after a sync.

// File: rtl/bitrep_pkg.sv
package bitrep_pkg;
  typedef enum logic {
    RATE_FULL    = 1'b0,
    RATE_QUARTER = 1'b1
  } rate_mode_t;
endpackage

// File: rtl/bitrep_ctrl.sv
module bitrep_ctrl
  import bitrep_pkg::*;
#(
  parameter int REP = 4,
  localparam int PH_W = (REP > 1) ? $clog2(REP) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic            in_sync,
  input  logic            mode_sel,
  output logic [PH_W-1:0] cur_phase,
  output rate_mode_t      cur_mode
);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(REP - 1);

  logic [PH_W-1:0] phase_q;
  rate_mode_t      mode_q;
  logic            sync_hit;

  assign sync_hit  = in_valid && in_sync;
  assign cur_phase = sync_hit ? '0 : phase_q;
  assign cur_mode  = sync_hit ? rate_mode_t'(mode_sel) : mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
      mode_q  <= RATE_FULL;
    end else begin
      if (in_valid)
        phase_q <= (cur_phase == PH_LAST) ? '0 : cur_phase + 1'b1;
      if (sync_hit)
        mode_q <= rate_mode_t'(mode_sel);
    end
  end

  assert_sync_restart_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_sync) |=> (phase_q == PH_W'(1 % REP)));

  assert_mode_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && in_sync) |=> $stable(mode_q));

  assert_idle_phase_R8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(phase_q));
endmodule

// File: rtl/bitrep_expand.sv
module bitrep_expand #(
  parameter int W   = 8,
  parameter int REP = 4,
  localparam int PH_W = (REP > 1) ? $clog2(REP) : 1
) (
  input  logic [W-1:0]    src,
  input  logic [PH_W-1:0] sel,
  output logic [W-1:0]    dst
);
  logic [W-1:0] cand [REP];

  for (genvar k = 0; k < REP; k++) begin : g_slot
    for (genvar p = 0; p < W; p++) begin : g_bit
      localparam int M   = W - 1 - p;
      localparam int G   = k * W + M;
      localparam int SRC = W - 1 - G / REP;
      assign cand[k][p] = src[SRC];
    end
  end

  always_comb begin
    dst = cand[0];
    for (int k = 1; k < REP; k++)
      if (sel == PH_W'(k)) dst = cand[k];
  end

  initial begin
    assert (W % REP == 0) else $error("W must be a multiple of REP");
  end
endmodule

// File: rtl/bitrep_top.sv
module bitrep_top
  import bitrep_pkg::*;
#(
  parameter int W   = 8,
  parameter int REP = 4,
  localparam int PH_W = (REP > 1) ? $clog2(REP) : 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] in_data,
  input  logic         in_valid,
  input  logic         in_sync,
  input  logic         mode_sel,
  output logic [W-1:0] out_data,
  output logic         out_valid
);
  logic [PH_W-1:0] cur_phase;
  rate_mode_t      cur_mode;
  logic [W-1:0]    hold_q;
  logic [W-1:0]    exp_src;
  logic [W-1:0]    exp_byte;

  bitrep_ctrl #(.REP(REP)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_sync   (in_sync),
    .mode_sel  (mode_sel),
    .cur_phase (cur_phase),
    .cur_mode  (cur_mode)
  );

  assign exp_src = (cur_phase == '0) ? in_data : hold_q;

  bitrep_expand #(.W(W), .REP(REP)) u_expand (
    .src (exp_src),
    .sel (cur_phase),
    .dst (exp_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q    <= '0;
      out_data  <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        if (cur_phase == '0) hold_q <= in_data;
        out_data <= (cur_mode == RATE_QUARTER) ? exp_byte : in_data;
      end
    end
  end

  assert_valid_follow_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid == $past(in_valid));

  assert_full_pass_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cur_mode == RATE_FULL) |=> (out_data == $past(in_data)));

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_data));

  for (genvar n = 0; n < W / REP * 0 + W / 4; n++) begin : g_nib
    if (REP == 4) begin : g_chk
      assert_nibble_run_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cur_mode == RATE_QUARTER) |=>
          (out_data[n*4 +: 4] == 4'h0 || out_data[n*4 +: 4] == 4'hF));
    end
  end
endmodule

// File: tb/tb_bitrep_top.sv
module tb_bitrep_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] in_data = '0;
  logic       in_valid = 1'b0;
  logic       in_sync = 1'b0;
  logic       mode_sel = 1'b0;
  logic [7:0] out_data;
  logic       out_valid;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bitrep_top dut (
    .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid),
    .in_sync(in_sync), .mode_sel(mode_sel),
    .out_data(out_data), .out_valid(out_valid)
  );

  function automatic logic [7:0] spread(input logic [7:0] b, input int k);
    logic hi, lo;
    hi = b[7 - 2*k];
    lo = b[6 - 2*k];
    return {{4{hi}}, {4{lo}}};
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one cycle, then sample one ns after the edge that registers it
  task automatic step(input logic [7:0] d, input logic v, input logic s, input logic m);
    @(negedge clk);
    in_data = d; in_valid = v; in_sync = s; mode_sel = m;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    check("R1 valid in reset", {7'd0, out_valid}, 8'd0);
    check("R1 data in reset", out_data, 8'h00);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    check("R1 valid after reset", {7'd0, out_valid}, 8'd0);
    check("R1 data after reset", out_data, 8'h00);
  endtask

  task automatic t_full;
    step(8'h3C, 1, 1, 0);
    check("R2 pass byte0", out_data, 8'h3C);
    check("R7 valid", {7'd0, out_valid}, 8'd1);
    step(8'h81, 1, 0, 0);
    check("R2 pass byte1", out_data, 8'h81);
    step(8'h7E, 1, 0, 1);
    check("R2 pass ignores mode_sel R6", out_data, 8'h7E);
    step(8'h55, 1, 0, 1);
    check("R2 pass byte3", out_data, 8'h55);
  endtask

  task automatic t_quarter(input logic [7:0] b);
    logic [7:0] junk [3] = '{8'h00, 8'hFF, 8'h5A};
    step(b, 1, 1, 1);
    check("R3 R5 slot0", out_data, spread(b, 0));
    for (int k = 1; k < 4; k++) begin
      step(junk[k-1] ^ b, 1, 0, 1);
      check("R3 R4 slot", out_data, spread(b, k));
    end
  endtask

  task automatic t_idle;
    step(8'hC3, 1, 1, 1);
    check("R3 slot0 before idle", out_data, spread(8'hC3, 0));
    for (int i = 0; i < 3; i++) begin
      step(8'h99, 0, 0, 1);
      check("R7 idle valid low", {7'd0, out_valid}, 8'd0);
      check("R8 idle holds data", out_data, spread(8'hC3, 0));
    end
    step(8'h11, 1, 0, 1);
    check("R8 phase kept across idle", out_data, spread(8'hC3, 1));
    check("R7 valid back", {7'd0, out_valid}, 8'd1);
  endtask

  task automatic t_resync;
    step(8'hF0, 1, 1, 1);
    step(8'h00, 1, 0, 1);
    check("R3 slot1 pre-resync", out_data, spread(8'hF0, 1));
    step(8'h96, 1, 1, 1);
    check("R5 resync slot0", out_data, spread(8'h96, 0));
    step(8'h00, 1, 0, 1);
    check("R5 resync slot1", out_data, spread(8'h96, 1));
  endtask

  task automatic t_mode_defer;
    step(8'hA5, 1, 1, 1);
    step(8'h00, 1, 0, 0);
    check("R6 no switch mid group", out_data, spread(8'hA5, 1));
    step(8'h00, 1, 0, 0);
    step(8'h00, 1, 0, 0);
    step(8'h6B, 1, 0, 0);
    check("R6 still quarter without sync", out_data, spread(8'h6B, 0));
    step(8'h6B, 1, 1, 0);
    check("R6 switch at sync", out_data, 8'h6B);
    step(8'h24, 1, 0, 0);
    check("R6 R2 full after switch", out_data, 8'h24);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset;
    t_full;
    t_quarter(8'hA5);
    check("R3 literal A5 last", out_data, 8'h0F);
    t_quarter(8'h3C);
    t_idle;
    t_resync;
    t_mode_defer;
    step(8'h00, 0, 0, 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule